// File: doc/BRIEF.md
# Transmit Dominant Time-out Guard

This block sits between the transmit-data input coming from a local microcontroller and the enable of a bus line driver. It passes a low transmit level to the driver as a dominant request while the node is in normal mode. It also makes sure that a transmit line stuck low cannot hold the shared bus dominant without limit. A free-running microsecond tick paces two small dwell counters. The first counts how long the dominant request has lasted. The second counts how long transmit data has been high after a trip.

When the dominant request outlasts a configured number of ticks, the guard latches the driver recessive and raises a timed-out status. The latch survives mode changes and is released only after transmit data has stayed high for a minimum number of consecutive ticks. A build-time option removes the limit entirely, so the bus follows transmit data for any length of dominant time.

Top module: `txd_dominant_guard`

## Requirements
- R1: `bus_dominant_o` is 1 (drive dominant) only while `txd_i` is 0, `normal_mode_i` is 1 and `timed_out_o` is 0; in that case it is 1 in the same cycle, with no register in the path.
- R2: A high level on `txd_i`, which is also the level an undriven transmit pin reads through its pull-up, always gives `bus_dominant_o` = 0.
- R3: With the limit enabled, counting starts from a cleared count. If `txd_i` = 0 and `normal_mode_i` = 1 hold for `TIMEOUT_US` cycles in which `tick_us_i` = 1, then from the edge of the last such tick `timed_out_o` = 1 and `bus_dominant_o` = 0. After `TIMEOUT_US`-1 such ticks, the driver is still dominant.
- R4: The dominant dwell count clears in any clock cycle with `txd_i` = 1 (a rising edge needs no tick) and in any cycle with `normal_mode_i` = 0. Cycles without a tick do not advance it.
- R5: Once set, `timed_out_o` stays 1 and holds the driver recessive while `txd_i` stays low, including across normal-mode exit and re-entry, until re-arming completes.
- R6: Re-arming completes, clearing `timed_out_o`, at the edge of the (`REARM_US`+1)-th consecutive tick with `txd_i` = 1. Any cycle with `txd_i` = 0 restarts that count.
- R7: With `NO_LIMIT` = 1, `timed_out_o` is constantly 0 and the driver follows R1 for any length of dominant time.
- R8: A synchronous active-low reset (`rst_n` = 0 at a clock edge) clears `timed_out_o` and both dwell counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txd_i | input | 1 | Transmit data from the microcontroller; 0 requests dominant |
| normal_mode_i | input | 1 | 1 while the node is in its transmitting (normal) mode |
| tick_us_i | input | 1 | One-cycle pulse once per microsecond |
| bus_dominant_o | output | 1 | 1 enables the low-side bus driver (dominant) |
| timed_out_o | output | 1 | 1 while the guard holds the driver recessive after a time-out |

## Verification
The assertions take for granted that `txd_i`, `normal_mode_i` and `tick_us_i` are already synchronous to `clk`, and that a tick lasts one cycle and never repeats back to back faster than the counters can observe. The stimulus drives every input only at the falling clock edge, and it steps ticks one cycle at a time under explicit control. Trip and release can therefore only follow a qualifying tick, which is exactly what the trip and re-arm properties check. The bench uses short limits (20 and 3) so that both boundaries, one tick short and exactly at the limit, are reached directly.

// File: rtl/txd_guard_pkg.sv
// Package: shared types for the transmit dominant time-out guard.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package txd_guard_pkg;

    // Guard state: ARMED lets dominant requests through, TRIPPED holds recessive.
    typedef enum logic {
        GUARD_ARMED   = 1'b0,
        GUARD_TRIPPED = 1'b1
    } guard_state_t;

    // Width needed to count from 0 up to and including a limit.
    function automatic int unsigned count_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/txd_dwell_counter.sv
// Module: txd_dwell_counter
// Counts qualified ticks up to LIMIT, clears on request, and flags the
// tick that completes the dwell. Assumes LIMIT >= 1 and that clear wins
// over count in the same cycle.
module txd_dwell_counter #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic count_i,
    output logic reach_o
);
    import txd_guard_pkg::*;

    localparam int unsigned CW = count_width(LIMIT);
    localparam logic [CW-1:0] LAST_VAL = CW'(LIMIT - 1);
    localparam logic [CW-1:0] FULL_VAL = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    // Dwell count: cleared on request, stops once the limit is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (count_i && (cnt_q != FULL_VAL)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Completion flag: this qualified tick is the LIMIT-th one.
    always_comb begin
        reach_o = count_i && !clear_i && (cnt_q == LAST_VAL);
    end

endmodule

// File: rtl/txd_guard_ctrl.sv
// Module: txd_guard_ctrl
// Two-state latch of the guard: trips on a completed dominant dwell and
// re-arms on a completed high dwell. Assumes both reach inputs are
// single-cycle pulses and are never set together.
module txd_guard_ctrl (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         trip_i,
    input  logic                         rearm_i,
    output txd_guard_pkg::guard_state_t  state_o
);
    import txd_guard_pkg::*;

    guard_state_t state_q;
    guard_state_t state_d;

    // Next state: trip only from ARMED, release only from TRIPPED.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GUARD_ARMED:   if (trip_i)  state_d = GUARD_TRIPPED;
            GUARD_TRIPPED: if (rearm_i) state_d = GUARD_ARMED;
            default:       state_d = GUARD_ARMED;
        endcase
    end

    // State register with synchronous reset to ARMED.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GUARD_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/txd_dominant_guard.sv
// Module: txd_dominant_guard (top)
// Gates the bus driver enable from transmit data and normal mode, and
// forces recessive after TIMEOUT_US ticks of continuous dominant request
// until transmit data has been high for REARM_US+1 ticks. NO_LIMIT = 1
// removes the guard. Assumes all inputs are synchronous to clk and the
// tick is a one-cycle pulse.
module txd_dominant_guard #(
    parameter int unsigned TIMEOUT_US = 13000,
    parameter int unsigned REARM_US   = 10,
    parameter bit          NO_LIMIT   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txd_i,
    input  logic normal_mode_i,
    input  logic tick_us_i,
    output logic bus_dominant_o,
    output logic timed_out_o
);
    import txd_guard_pkg::*;

    localparam int unsigned REARM_TICKS = REARM_US + 1;

    logic dom_request;
    logic tripped;

    // Raw dominant request: low transmit data while in normal mode.
    always_comb begin
        dom_request = normal_mode_i && !txd_i;
    end

    generate
        if (NO_LIMIT) begin : g_open
            logic unused_inputs;
            // No guard: the latch is permanently armed.
            always_comb begin
                unused_inputs = clk ^ rst_n ^ tick_us_i;
                tripped       = 1'b0;
            end
        end else begin : g_guarded
            guard_state_t state;
            logic dom_clear, dom_count, dom_reach;
            logic hi_clear,  hi_count,  hi_reach;

            // Qualifiers for the dominant dwell and the re-arm dwell.
            always_comb begin
                dom_clear = !dom_request;
                dom_count = dom_request && tick_us_i && (state == GUARD_ARMED);
                hi_clear  = !txd_i || (state == GUARD_ARMED);
                hi_count  = txd_i && tick_us_i && (state == GUARD_TRIPPED);
            end

            txd_dwell_counter #(.LIMIT(TIMEOUT_US)) i_dom_dwell (
                .clk     (clk),
                .rst_n   (rst_n),
                .clear_i (dom_clear),
                .count_i (dom_count),
                .reach_o (dom_reach)
            );

            txd_dwell_counter #(.LIMIT(REARM_TICKS)) i_high_dwell (
                .clk     (clk),
                .rst_n   (rst_n),
                .clear_i (hi_clear),
                .count_i (hi_count),
                .reach_o (hi_reach)
            );

            txd_guard_ctrl i_ctrl (
                .clk     (clk),
                .rst_n   (rst_n),
                .trip_i  (dom_reach),
                .rearm_i (hi_reach),
                .state_o (state)
            );

            // Latched status from the control state.
            always_comb begin
                tripped = (state == GUARD_TRIPPED);
            end
        end
    endgenerate

    // Output gating: dominant only while requested and not tripped.
    always_comb begin
        bus_dominant_o = dom_request && !tripped;
        timed_out_o    = tripped;
    end

endmodule

// File: rtl/txd_dominant_guard_chk.sv
// Module: txd_dominant_guard_chk
// Property checker for txd_dominant_guard, bound to every instance.
// Assumes inputs are synchronous to clk.
module txd_dominant_guard_chk #(
    parameter bit NO_LIMIT = 1'b0
) (
    input logic clk,
    input logic rst_n,
    input logic txd_i,
    input logic normal_mode_i,
    input logic tick_us_i,
    input logic bus_dominant_o,
    input logic timed_out_o
);

    AST_HIGH_IS_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        txd_i |-> !bus_dominant_o);                                     // R2

    AST_MODE_GATES_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        !normal_mode_i |-> !bus_dominant_o);                            // R1

    AST_TRIP_HOLDS_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        timed_out_o |-> !bus_dominant_o);                               // R5

    AST_TRIP_NEEDS_LOW_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(timed_out_o) && $past(rst_n))
            |-> $past(!txd_i && normal_mode_i && tick_us_i));           // R3

    AST_REARM_NEEDS_HIGH_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(timed_out_o) && $past(rst_n))
            |-> $past(txd_i && tick_us_i));                             // R6

    AST_LOW_KEEPS_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (timed_out_o && !txd_i) |=> timed_out_o);                       // R5

    generate
        if (NO_LIMIT) begin : g_open_chk
            AST_NO_LIMIT_NEVER_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
                !timed_out_o);                                          // R7
        end
    endgenerate

endmodule

bind txd_dominant_guard txd_dominant_guard_chk #(.NO_LIMIT(NO_LIMIT)) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .txd_i          (txd_i),
    .normal_mode_i  (normal_mode_i),
    .tick_us_i      (tick_us_i),
    .bus_dominant_o (bus_dominant_o),
    .timed_out_o    (timed_out_o)
);

// File: tb/test_txd_dominant_guard.sv
module test_txd_dominant_guard;

    localparam int unsigned TO_TICKS = 20;
    localparam int unsigned RA_US    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txd = 1'b1;
    logic nm = 1'b0;
    logic tick = 1'b0;
    logic dom, tout, dom_open, tout_open;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    txd_dominant_guard #(.TIMEOUT_US(TO_TICKS), .REARM_US(RA_US), .NO_LIMIT(1'b0)) i_txd_dominant_guard (
        .clk(clk), .rst_n(rst_n), .txd_i(txd), .normal_mode_i(nm), .tick_us_i(tick),
        .bus_dominant_o(dom), .timed_out_o(tout));

    txd_dominant_guard #(.TIMEOUT_US(TO_TICKS), .REARM_US(RA_US), .NO_LIMIT(1'b1)) i_txd_dominant_guard_open (
        .clk(clk), .rst_n(rst_n), .txd_i(txd), .normal_mode_i(nm), .tick_us_i(tick),
        .bus_dominant_o(dom_open), .timed_out_o(tout_open));

    // Vector: {txd, normal, tick, expected dominant, expected timed_out}
    localparam logic [4:0] VEC [8] = '{
        5'b11000, 5'b01010, 5'b00100, 5'b10100,
        5'b01110, 5'b11100, 5'b01110, 5'b00000
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Apply inputs after a falling edge; the next rising edge consumes them.
    task automatic step(input logic t, input logic n, input logic k);
        @(negedge clk);
        txd = t; nm = n; tick = k;
        #1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: got hung expected done");
        finish_run();
    end

    initial begin
        // R8 reset state
        step(1, 0, 0); step(1, 0, 0);
        rst_n = 1'b1;
        step(1, 0, 0);
        chk("R8 reset flag", tout, 1'b0);
        chk("R2 reset recessive", dom, 1'b0);

        // R1/R2/R4 table walk
        foreach (VEC[i]) begin
            step(VEC[i][4], VEC[i][3], VEC[i][2]);
            chk("R1 table dominant", dom, VEC[i][1]);
            chk("R2 table flag", tout, VEC[i][0]);
        end

        // R3 trip boundary
        step(1, 1, 0);
        for (int i = 0; i < TO_TICKS; i++) step(0, 1, 1);
        chk("R3 dominant before last tick", dom, 1'b1);
        step(0, 1, 0);
        chk("R3 recessive after limit", dom, 1'b0);
        chk("R3 flag after limit", tout, 1'b1);

        // R6 re-arm interrupted by a low cycle
        for (int i = 0; i < RA_US; i++) step(1, 1, 1);
        step(0, 1, 0);
        chk("R6 still tripped short high", tout, 1'b1);
        chk("R5 held recessive", dom, 1'b0);
        for (int i = 0; i < 5; i++) step(1, 1, 0);
        chk("R6 no tick no re-arm", tout, 1'b1);
        for (int i = 0; i < RA_US + 1; i++) step(1, 1, 1);
        chk("R6 flag before last re-arm edge", tout, 1'b1);
        step(1, 1, 0);
        chk("R6 re-armed", tout, 1'b0);
        step(0, 1, 0);
        chk("R6 dominant after re-arm", dom, 1'b1);

        // R4 normal-mode exit clears the dwell
        for (int i = 0; i < 15; i++) step(0, 1, 1);
        step(0, 0, 0);
        for (int i = 0; i < 15; i++) step(0, 1, 1);
        step(0, 1, 0);
        chk("R4 mode exit cleared count", dom, 1'b1);
        chk("R4 no trip after mode exit", tout, 1'b0);

        // R4 high cycle without tick clears; counting resumes to R3
        step(1, 1, 0);
        for (int i = 0; i < 15; i++) step(0, 1, 1);
        step(0, 1, 0);
        chk("R4 rising edge cleared count", dom, 1'b1);
        for (int i = 0; i < 5; i++) step(0, 1, 1);
        step(0, 1, 0);
        chk("R3 trip after resumed count", tout, 1'b1);

        // R5 latch survives mode exit and re-entry
        for (int i = 0; i < 3; i++) step(0, 0, 1);
        chk("R5 flag across mode exit", tout, 1'b1);
        step(0, 1, 0);
        chk("R5 recessive on re-entry", dom, 1'b0);

        // R8 reset releases the latch
        rst_n = 1'b0;
        step(0, 1, 0);
        rst_n = 1'b1;
        step(0, 1, 0);
        chk("R8 reset clears flag", tout, 1'b0);
        chk("R8 dominant after reset", dom, 1'b1);

        // R7 no-limit variant
        step(1, 1, 0);
        for (int i = 0; i < 3 * TO_TICKS; i++) step(0, 1, 1);
        step(0, 1, 0);
        chk("R7 open still dominant", dom_open, 1'b1);
        chk("R7 open never trips", tout_open, 1'b0);
        chk("R3 guarded tripped same stimulus", tout, 1'b1);

        step(1, 1, 0);
        finish_run();
    end

endmodule